// File: doc/BRIEF.md
# Frame-Synchronous Line Control Register

This block holds the control word for a four-wire subscriber line interface. A host writes a control word at any time. The word lands in a shadow copy. A working copy takes the shadow's value only at the next serial frame boundary. The working copy sets several outputs:

- one-cycle activation and deactivation requests for the line state machine;
- the placement of the signalling channel, either in its normal 16 kbit/s slot or in the first bearer timeslot at 64 kbit/s;
- the choice between fixed timing and adaptive line-length compensation;
- the marker bit sent in each half-frame;
- the forcing of a multiframe pattern onto the auxiliary framing bit and the N bit.

When the word's top bit is set, the write goes to a separate diagnostic register instead of the control path. A connection-ready flag drops when a new configuration is applied. It returns at the second frame boundary after that, which gives one frame to capture the configuration and one to establish the connection. The host side uses a valid/ready handshake. `wr_ready` is high in every cycle after reset, so the block never applies back-pressure. A beat is taken on every clock edge where both signals are high.

Control word fields:

| Bit | Meaning |
|-----|---------|
| 0 | Activate request |
| 1 | Deactivate request |
| 2 | Signalling channel moved into the first bearer slot |
| 3 | Adaptive timing |
| 4 | M value |
| 5 | S value |
| 6 | Multiframe force |
| 7 | Diagnostic select |

Top module: `linectl_frame_reg`

## Requirements
- R1: After reset:
  - the working configuration is all zero;
  - `link_ready` is 1 and `fa_bit` is 0;
  - `n_bit` is 1 and `ms_bit` is 0;
  - both request pulses are 0 and `diag_q` is 0.
- R2: A control write (bit 7 = 0) does not change any output until a `frame_start` cycle. At the clock edge of the first `frame_start` after the write, the working copy loads the shadow.
- R3: When several control writes fall within one frame, only the last one is applied at the boundary.
- R4: Activation request.
  - An applied word with bit 0 = 1 and bit 1 = 0 makes `act_req` high for exactly the one cycle after the boundary edge.
  - An applied word with bit 0 = 0 gives no activation pulse.
- R5: Deactivation request.
  - An applied word with bit 1 = 1 makes `deact_req` high for one cycle, even when bit 0 is also set. In that case no activation pulse occurs.
  - An applied word with bits 0 and 1 both 0 gives no pulse.
- R6: `d_in_b1` follows bit 2 of the working word. `adaptive_timing` follows bit 3, where 0 is fixed timing and 1 is adaptive.
- R7: `ms_bit` equals working bit 4 (the M value) while `half_sel` is 0, and working bit 5 (the S value) while `half_sel` is 1.
- R8: While working bit 6 is 1 and `half_sel` is 0, `fa_bit` is 1 and `n_bit` is 0. In every other case `fa_bit` is 0 and `n_bit` is 1.
- R9: A write with bit 7 = 1 loads bits 6:0 into `diag_q` on its own clock edge. It leaves the control shadow untouched, so the next boundary applies nothing, emits no request pulse and keeps `link_ready` high.
- R10: `link_ready` falls in the cycle after a boundary that applies a control word. It rises in the cycle after the second boundary following that one.
- R11: `wr_ready` is 1 in every cycle after the first clock edge out of reset. A beat is accepted on every edge where `wr_valid` is 1.
- R12: A control write accepted on the same edge as `frame_start` is not applied at that boundary. It is applied at the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write beat accepted |
| wr_data | input | 8 | Control word or diagnostic write |
| frame_start | input | 1 | One-cycle pulse at each serial frame boundary |
| half_sel | input | 1 | Current half-frame (0 first, 1 second) |
| act_req | output | 1 | One-cycle line activation request |
| deact_req | output | 1 | One-cycle line deactivation request |
| d_in_b1 | output | 1 | Signalling channel moved into first bearer slot |
| adaptive_timing | output | 1 | 1 selects adaptive line-length compensation |
| ms_bit | output | 1 | Transmitted half-frame marker bit |
| fa_bit | output | 1 | Auxiliary framing bit |
| n_bit | output | 1 | N framing bit |
| diag_q | output | 7 | Diagnostic register contents |
| link_ready | output | 1 | Configuration settled and connection established |

## Verification
The hardest situation to reach is a control write that arrives on the very edge of a frame boundary, because the old shadow is being applied while the new word is being taken. The bench drives `wr_valid` and `frame_start` in the same cycle. It then checks that the boundary leaves the outputs alone and that the following boundary applies the word. Two other cases also need a set-up sequence:

- The deactivate-over-activate case needs a word with both request bits set to reach a boundary.
- The diagnostic-only write can only be shown to have no effect after `link_ready` has settled high, so the bench first idles two frames. It then confirms that a later boundary emits nothing, even though the diagnostic word carries bits that would otherwise request activation and force the multiframe pattern.

// File: rtl/linectl_pkg.sv
package linectl_pkg;
  localparam int WORD_W   = 8;
  localparam int B_ACT    = 0;
  localparam int B_DEACT  = 1;
  localparam int B_DB1    = 2;
  localparam int B_ADAPT  = 3;
  localparam int B_MVAL   = 4;
  localparam int B_SVAL   = 5;
  localparam int B_MFF    = 6;
  localparam int B_SEL    = 7;

  typedef struct packed {
    logic mf_force;
    logic s_val;
    logic m_val;
    logic adaptive;
    logic d_in_b1;
  } line_cfg_t;

  function automatic line_cfg_t decode_cfg(input logic [WORD_W-1:0] w);
    line_cfg_t c;
    c.mf_force = w[B_MFF];
    c.s_val    = w[B_SVAL];
    c.m_val    = w[B_MVAL];
    c.adaptive = w[B_ADAPT];
    c.d_in_b1  = w[B_DB1];
    return c;
  endfunction
endpackage

// File: rtl/linectl_shadow.sv
module linectl_shadow
  import linectl_pkg::*;
#(
  parameter int DIAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [WORD_W-1:0] data,
  input  logic              boundary,
  output logic [WORD_W-1:0] shadow_word,
  output logic              pending,
  output logic [DIAG_W-1:0] diag_word
);
  logic ctrl_wr;
  logic diag_wr;

  assign ctrl_wr = beat && !data[B_SEL];
  assign diag_wr = beat &&  data[B_SEL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_word <= '0;
      pending     <= 1'b0;
      diag_word   <= '0;
    end else begin
      if (ctrl_wr) begin
        shadow_word <= data;
      end
      if (ctrl_wr) begin
        pending <= 1'b1;
      end else if (boundary) begin
        pending <= 1'b0;
      end
      if (diag_wr) begin
        diag_word <= data[DIAG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/linectl_apply.sv
module linectl_apply
  import linectl_pkg::*;
#(
  parameter int SETTLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              pending,
  input  logic [WORD_W-1:0] shadow_word,
  output line_cfg_t         cfg,
  output logic              act_pulse,
  output logic              deact_pulse,
  output logic              ready
);
  logic load;
  assign load = boundary && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg         <= '0;
      act_pulse   <= 1'b0;
      deact_pulse <= 1'b0;
    end else begin
      if (load) begin
        cfg <= decode_cfg(shadow_word);
      end
      act_pulse   <= load && shadow_word[B_ACT] && !shadow_word[B_DEACT];
      deact_pulse <= load && shadow_word[B_DEACT];
    end
  end

  generate
    if (SETTLE_FRAMES == 0) begin : g_no_settle
      assign ready = 1'b1;
    end else begin : g_settle
      localparam int CNT_W = $clog2(SETTLE_FRAMES + 1);
      localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_FRAMES);
      logic [CNT_W-1:0] left_q;
      logic             ready_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          left_q  <= '0;
          ready_q <= 1'b1;
        end else if (load) begin
          left_q  <= CNT_INIT;
          ready_q <= 1'b0;
        end else if (boundary && (left_q != '0)) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            ready_q <= 1'b1;
          end
        end
      end
      assign ready = ready_q;
    end
  endgenerate
endmodule

// File: rtl/linectl_txbits.sv
module linectl_txbits
  import linectl_pkg::*;
(
  input  line_cfg_t cfg,
  input  logic      half,
  output logic      ms,
  output logic      fa,
  output logic      n
);
  always_comb begin
    ms = half ? cfg.s_val : cfg.m_val;
    fa = cfg.mf_force && !half;
    n  = !(cfg.mf_force && !half);
  end
endmodule

// File: rtl/linectl_frame_reg.sv
module linectl_frame_reg
  import linectl_pkg::*;
#(
  parameter int DIAG_W        = 7,
  parameter int SETTLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_start,
  input  logic              half_sel,
  output logic              act_req,
  output logic              deact_req,
  output logic              d_in_b1,
  output logic              adaptive_timing,
  output logic              ms_bit,
  output logic              fa_bit,
  output logic              n_bit,
  output logic [DIAG_W-1:0] diag_q,
  output logic              link_ready
);
  logic              accept_en;
  logic              beat;
  logic [WORD_W-1:0] shadow_w;
  logic              pending_w;
  line_cfg_t         cfg_w;

  always_ff @(posedge clk) begin
    if (!rst_n) accept_en <= 1'b0;
    else        accept_en <= 1'b1;
  end

  assign wr_ready = accept_en;
  assign beat     = wr_valid && accept_en;

  linectl_shadow #(.DIAG_W(DIAG_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .data       (wr_data),
    .boundary   (frame_start),
    .shadow_word(shadow_w),
    .pending    (pending_w),
    .diag_word  (diag_q)
  );

  linectl_apply #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_apply (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (frame_start),
    .pending    (pending_w),
    .shadow_word(shadow_w),
    .cfg        (cfg_w),
    .act_pulse  (act_req),
    .deact_pulse(deact_req),
    .ready      (link_ready)
  );

  linectl_txbits u_tx (
    .cfg (cfg_w),
    .half(half_sel),
    .ms  (ms_bit),
    .fa  (fa_bit),
    .n   (n_bit)
  );

  assign d_in_b1         = cfg_w.d_in_b1;
  assign adaptive_timing = cfg_w.adaptive;
endmodule

// File: rtl/linectl_frame_reg_chk.sv
module linectl_frame_reg_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ready,
  input logic frame_start,
  input logic half_sel,
  input logic pending,
  input logic act_req,
  input logic deact_req,
  input logic d_in_b1,
  input logic adaptive_timing,
  input logic fa_bit,
  input logic n_bit,
  input logic link_ready
);
  p_always_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);

  p_act_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |=> !act_req);

  p_deact_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);

  p_req_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_req && deact_req));

  p_req_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req || deact_req) |-> $past(frame_start));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(d_in_b1) && $stable(adaptive_timing)));

  p_fa_first_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fa_bit |-> (!n_bit && !half_sel));

  p_ready_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ready) |-> $past(frame_start && pending));

  p_ready_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(frame_start));
endmodule

bind linectl_frame_reg linectl_frame_reg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_ready       (wr_ready),
  .frame_start    (frame_start),
  .half_sel       (half_sel),
  .pending        (pending_w),
  .act_req        (act_req),
  .deact_req      (deact_req),
  .d_in_b1        (d_in_b1),
  .adaptive_timing(adaptive_timing),
  .fa_bit         (fa_bit),
  .n_bit          (n_bit),
  .link_ready     (link_ready)
);

// File: tb/sim_linectl_frame_reg.sv
module sim_linectl_frame_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       frame_start = 1'b0;
  logic       half_sel = 1'b0;
  logic       act_req, deact_req, d_in_b1, adaptive_timing;
  logic       ms_bit, fa_bit, n_bit, link_ready;
  logic [6:0] diag_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  linectl_frame_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .frame_start(frame_start), .half_sel(half_sel),
    .act_req(act_req), .deact_req(deact_req), .d_in_b1(d_in_b1),
    .adaptive_timing(adaptive_timing), .ms_bit(ms_bit), .fa_bit(fa_bit),
    .n_bit(n_bit), .diag_q(diag_q), .link_ready(link_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic frame_tick();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 d_in_b1", d_in_b1, 0);
    check("R1 adaptive", adaptive_timing, 0);
    check("R1 link_ready", link_ready, 1);
    check("R1 fa", fa_bit, 0);
    check("R1 n", n_bit, 1);
    check("R1 ms", ms_bit, 0);
    check("R1 pulses", {act_req, deact_req}, 0);
    check("R1 diag", diag_q, 0);
    @(negedge clk);
    check("R11 wr_ready", wr_ready, 1);
  endtask

  task automatic t_deferred();
    host_write(8'h0C);
    check("R2 d_in_b1 before boundary", d_in_b1, 0);
    check("R2 adaptive before boundary", adaptive_timing, 0);
    frame_tick();
    check("R6 d_in_b1", d_in_b1, 1);
    check("R6 adaptive", adaptive_timing, 1);
    check("R10 ready falls", link_ready, 0);
  endtask

  task automatic t_ready();
    repeat (3) @(negedge clk);
    check("R10 low between", link_ready, 0);
    frame_tick();
    check("R10 low after first frame", link_ready, 0);
    frame_tick();
    check("R10 high after second frame", link_ready, 1);
  endtask

  task automatic t_last_wins();
    host_write(8'h04);
    host_write(8'h08);
    frame_tick();
    check("R3 d_in_b1 from last write", d_in_b1, 0);
    check("R3 adaptive from last write", adaptive_timing, 1);
  endtask

  task automatic t_act();
    host_write(8'h01);
    check("R4 no pulse before boundary", act_req, 0);
    frame_tick();
    check("R4 act pulse", act_req, 1);
    check("R4 no deact", deact_req, 0);
    @(negedge clk);
    check("R4 act single cycle", act_req, 0);
  endtask

  task automatic t_prio();
    host_write(8'h03);
    frame_tick();
    check("R5 deact pulse", deact_req, 1);
    check("R5 act suppressed", act_req, 0);
    @(negedge clk);
    check("R5 deact single cycle", deact_req, 0);
    host_write(8'h00);
    frame_tick();
    check("R5 no pulses for zero bits", {act_req, deact_req}, 0);
  endtask

  task automatic t_ms();
    host_write(8'h10);
    frame_tick();
    half_sel = 1'b0; #1;
    check("R7 M in first half", ms_bit, 1);
    half_sel = 1'b1; #1;
    check("R7 S in second half", ms_bit, 0);
    host_write(8'h20);
    frame_tick();
    #1;
    check("R7 S value second half", ms_bit, 1);
    half_sel = 1'b0; #1;
    check("R7 M value first half", ms_bit, 0);
  endtask

  task automatic t_mf();
    host_write(8'h40);
    frame_tick();
    half_sel = 1'b0; #1;
    check("R8 fa forced", fa_bit, 1);
    check("R8 n forced", n_bit, 0);
    half_sel = 1'b1; #1;
    check("R8 fa second half", fa_bit, 0);
    check("R8 n second half", n_bit, 1);
    half_sel = 1'b0;
    host_write(8'h00);
    frame_tick();
    #1;
    check("R8 fa restored", fa_bit, 0);
    check("R8 n restored", n_bit, 1);
  endtask

  task automatic t_diag();
    frame_tick();
    frame_tick();
    check("R9 ready settled", link_ready, 1);
    host_write(8'hD5);
    check("R9 diag loaded", diag_q, 7'h55);
    frame_tick();
    check("R9 no act pulse", act_req, 0);
    check("R9 fa not forced", fa_bit, 0);
    check("R9 d_in_b1 unchanged", d_in_b1, 0);
    check("R9 ready kept", link_ready, 1);
  endtask

  task automatic t_coincident();
    @(negedge clk);
    wr_valid    = 1'b1;
    wr_data     = 8'h04;
    frame_start = 1'b1;
    @(negedge clk);
    wr_valid    = 1'b0;
    frame_start = 1'b0;
    check("R12 not applied at same boundary", d_in_b1, 0);
    check("R12 ready unaffected", link_ready, 1);
    frame_tick();
    check("R12 applied at next boundary", d_in_b1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deferred();
    t_ready();
    t_last_wins();
    t_act();
    t_prio();
    t_ms();
    t_mf();
    t_diag();
    t_coincident();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule